// File: doc/BRIEF.md
# Configurable LUT Logic Cell

This block is one logic cell for a fine-grained programmable fabric. Two 3-input lookup tables share the cell's three data inputs. They can act as two separate functions, or the fourth input can choose between their outputs so that the cell computes any single 4-input function. An AND gate in front of the tables can merge the lowest data input with a partner input, which is useful when tiling array multipliers. A 2-to-1 multiplexer picks the flip-flop's data from the table result or from a direct bypass input. The flip-flop has synchronous clear and set, and its state can be routed back in place of the top table input.

A configuration word holds the table contents and the mode bits. It is written either in one cycle through a parallel port or one bit per cycle through a serial shift path. While a configuration write is under way, the flip-flop does not capture data. Each output carries a data bit and a matching enable bit, standing in for a tri-state driver. When an output is disabled, its data bit reads 0.

Top module: `lut_logic_cell`

## Requirements
- R1: In split mode (cfg bit 16 = 0), f_o equals lut_a[{x2,x1,x0}] and g_o equals lut_b[{x2,x1,x0}]. lut_a is held in cfg bits 7:0 and lut_b in cfg bits 15:8. Table index bit k selects entry k.
- R2: In joined mode (cfg bit 16 = 1), f_o equals the 16-bit table {lut_b,lut_a} indexed by {w_i,x2,x1,x0}, and g_o reads 0.
- R3: When cfg bit 17 is 1, the table index uses x_i[0] & m_i in place of x_i[0].
- R4: When cfg bit 18 is 1, the table index uses the flip-flop state in place of x_i[2].
- R5: On each clock edge the flip-flop is cleared when clr_i is 1. Otherwise it is set when set_i is 1. Otherwise it captures data when ce_i is 1, and otherwise it holds.
- R6: While cfg_we_i is 1, the flip-flop does not capture data. clr_i and set_i still act.
- R7: The captured data is the combined table result when cfg bit 19 is 0, and d_i when it is 1.
- R8: cfg bit 21 enables f_o and g_o, with f_en_o reflecting it. cfg bit 20 enables q_o, with q_en_o reflecting it. A disabled output reads 0, and disabling an output leaves the flip-flop state unchanged.
- R9: cfg_we_i=1 with cfg_par_i=1 loads cfg_word_i into the configuration at the clock edge.
- R10: cfg_we_i=1 with cfg_par_i=0 shifts the configuration up by one bit and places cfg_bit_i in bit 0. After 22 shifts, the first bit sent sits in bit 21.
- R11: After reset, the configuration and the flip-flop are 0, so every output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_par_i | input | 1 | 1: parallel load, 0: serial shift |
| cfg_bit_i | input | 1 | Serial configuration bit |
| cfg_word_i | input | 22 | Parallel configuration word |
| x_i | input | 3 | Shared table inputs |
| w_i | input | 1 | Fourth input, selects between the tables in joined mode |
| m_i | input | 1 | Partner input of the front AND gate |
| d_i | input | 1 | Direct flip-flop data |
| ce_i | input | 1 | Flip-flop capture enable |
| set_i | input | 1 | Synchronous set |
| clr_i | input | 1 | Synchronous clear |
| f_o | output | 1 | Combinational result |
| f_en_o | output | 1 | Enable of f_o and g_o |
| g_o | output | 1 | Second table result, split mode only |
| q_o | output | 1 | Registered result |
| q_en_o | output | 1 | Enable of q_o |

## Verification
The bench aims at the following corner cases:

- **Clear and set together.** A design that ranks set above clear would leave the cell at 1 when both are raised.
- **Capture during a configuration write.** A design that ignores the write would latch data computed from a table that is being replaced.
- **Feedback toggling.** The register toggles through its own state. A wrong index bit, or a feedback tap taken after the output gate, shows up as a stuck register once the output is disabled.
- **Serial order over a full word.** The bench shifts in a complete 22-bit word and then checks every table entry, so an off-by-one or reversed shift appears as corrupted contents.
- **Joined-mode index.** Sweeping all 16 index values catches swapped tables or a wrong select polarity.

// File: rtl/lcell_pkg.sv
`timescale 1ns/1ps
package lcell_pkg;
  localparam int LUT_IN    = 3;
  localparam int LUT_DEPTH = 1 << LUT_IN;
  localparam int MODE_BITS = 6;
  localparam int CFG_W     = 2 * LUT_DEPTH + MODE_BITS;

  typedef struct packed {
    logic                 f_oe;
    logic                 q_oe;
    logic                 d_src;
    logic                 fb_en;
    logic                 and_en;
    logic                 join4;
    logic [LUT_DEPTH-1:0] lut_b;
    logic [LUT_DEPTH-1:0] lut_a;
  } cfg_t;
endpackage

// File: rtl/lcell_lut.sv
`timescale 1ns/1ps
module lcell_lut #(
  parameter int N = 3,
  localparam int D = 1 << N
) (
  input  logic [D-1:0] table_i,
  input  logic [N-1:0] sel_i,
  output logic         y_o
);
  assign y_o = table_i[sel_i];
endmodule

// File: rtl/lcell_cfg_store.sv
`timescale 1ns/1ps
module lcell_cfg_store
  import lcell_pkg::*;
#(
  parameter int W = CFG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic         par_i,
  input  logic         bit_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] cfg_o
);
  logic [W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cfg_q <= '0;
    else if (we_i) begin
      if (par_i)          cfg_q <= word_i;
      else                cfg_q <= {cfg_q[W-2:0], bit_i};
    end
  end

  assign cfg_o = cfg_q;

  AST_PAR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && par_i) |=> (cfg_o == $past(word_i))); // R9
  AST_SER_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !par_i) |=> (cfg_o == {$past(cfg_o[W-2:0]), $past(bit_i)})); // R10
  AST_CFG_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_o)); // R9
endmodule

// File: rtl/lcell_ff.sv
`timescale 1ns/1ps
module lcell_ff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_i,
  input  logic cap_i,
  input  logic d_i,
  output logic q_o
);
  logic q_q;

  // clear > set > capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= 1'b0;
    else if (clr_i)  q_q <= 1'b0;
    else if (set_i)  q_q <= 1'b1;
    else if (cap_i)  q_q <= d_i;
  end

  assign q_o = q_q;

  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !q_o); // R5
  AST_SET_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && set_i) |=> q_o); // R5
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i && !cap_i) |=> $stable(q_o)); // R6
  AST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i && cap_i) |=> (q_o == $past(d_i))); // R5
endmodule

// File: rtl/lut_logic_cell.sv
`timescale 1ns/1ps
module lut_logic_cell
  import lcell_pkg::*;
#(
  parameter int N_LUT = 2,
  localparam int IN_W = LUT_IN,
  localparam int CW   = CFG_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic            cfg_par_i,
  input  logic            cfg_bit_i,
  input  logic [CW-1:0]   cfg_word_i,
  input  logic [IN_W-1:0] x_i,
  input  logic            w_i,
  input  logic            m_i,
  input  logic            d_i,
  input  logic            ce_i,
  input  logic            set_i,
  input  logic            clr_i,
  output logic            f_o,
  output logic            f_en_o,
  output logic            g_o,
  output logic            q_o,
  output logic            q_en_o
);
  logic [CW-1:0]        cfg_raw;
  cfg_t                 cfg;
  logic [IN_W-1:0]      idx;
  logic [LUT_DEPTH-1:0] tab [N_LUT];
  logic [N_LUT-1:0]     lut_y;
  logic                 f_comb, ff_d, ff_q, ff_cap;

  lcell_cfg_store #(.W(CW)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .par_i  (cfg_par_i),
    .bit_i  (cfg_bit_i),
    .word_i (cfg_word_i),
    .cfg_o  (cfg_raw)
  );
  assign cfg = cfg_t'(cfg_raw);

  // front AND on bit 0, feedback on the top bit
  always_comb begin
    idx          = x_i;
    idx[0]       = cfg.and_en ? (x_i[0] & m_i) : x_i[0];
    idx[IN_W-1]  = cfg.fb_en  ? ff_q : x_i[IN_W-1];
  end

  assign tab[0] = cfg.lut_a;
  assign tab[1] = cfg.lut_b;

  for (genvar g = 0; g < N_LUT; g++) begin : g_lut
    lcell_lut #(.N(IN_W)) u_lut (
      .table_i (tab[g]),
      .sel_i   (idx),
      .y_o     (lut_y[g])
    );
  end

  // joined mode: w_i picks between the two tables
  assign f_comb = (cfg.join4 && w_i) ? lut_y[1] : lut_y[0];
  assign ff_d   = cfg.d_src ? d_i : f_comb;
  assign ff_cap = ce_i & ~cfg_we_i;

  lcell_ff u_ff (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .set_i  (set_i),
    .cap_i  (ff_cap),
    .d_i    (ff_d),
    .q_o    (ff_q)
  );

  assign f_en_o = cfg.f_oe;
  assign f_o    = cfg.f_oe & f_comb;
  assign g_o    = cfg.f_oe & ~cfg.join4 & lut_y[1];
  assign q_en_o = cfg.q_oe;
  assign q_o    = cfg.q_oe & ff_q;

  AST_WE_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !clr_i && !set_i) |=> $stable(ff_q)); // R6
  AST_Q_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_en_o |-> !q_o); // R8
endmodule

// File: tb/lut_logic_cell_tb_top.sv
`timescale 1ns/1ps
module lut_logic_cell_tb_top;
  localparam int CW = 22;

  logic clk = 0, rst_ni = 0;
  logic cfg_we, cfg_par, cfg_bit;
  logic [CW-1:0] cfg_word;
  logic [2:0] x;
  logic w, m, d, ce, set_s, clr;
  logic f_o, f_en_o, g_o, q_o, q_en_o;

  int vectors = 0, errors = 0;
  bit done = 0;
  logic [CW-1:0] m_cfg;
  logic m_q;

  always #4 clk = ~clk;

  lut_logic_cell dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_par_i(cfg_par),
    .cfg_bit_i(cfg_bit), .cfg_word_i(cfg_word), .x_i(x), .w_i(w), .m_i(m),
    .d_i(d), .ce_i(ce), .set_i(set_s), .clr_i(clr),
    .f_o(f_o), .f_en_o(f_en_o), .g_o(g_o), .q_o(q_o), .q_en_o(q_en_o)
  );

  function automatic logic [CW-1:0] mk(input logic [7:0] a, input logic [7:0] b,
      input logic j4, input logic an, input logic fb, input logic ds,
      input logic qoe, input logic foe);
    return {foe, qoe, ds, fb, an, j4, b, a};
  endfunction

  function automatic logic model_f();
    logic [3:0] i;
    logic [15:0] t;
    i[0] = m_cfg[17] ? (x[0] & m) : x[0];
    i[1] = x[1];
    i[2] = m_cfg[18] ? m_q : x[2];
    i[3] = m_cfg[16] ? w : 1'b0;
    t = m_cfg[15:0];
    return t[i];
  endfunction

  function automatic logic model_g();
    logic [2:0] i;
    i[0] = m_cfg[17] ? (x[0] & m) : x[0];
    i[1] = x[1];
    i[2] = m_cfg[18] ? m_q : x[2];
    return m_cfg[8 + i];
  endfunction

  task automatic cmp(input string tag, input string nm, input logic act, input logic exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b (vector %0d)", tag, nm, act, exp, vectors);
    end
  endtask

  task automatic check_now(input string tag);
    logic fc;
    fc = model_f();
    vectors++;
    cmp(tag, "f_o",    f_o,    m_cfg[21] & fc);
    cmp(tag, "f_en_o", f_en_o, m_cfg[21]);
    cmp(tag, "g_o",    g_o,    m_cfg[21] & ~m_cfg[16] & model_g());
    cmp(tag, "q_o",    q_o,    m_cfg[20] & m_q);
    cmp(tag, "q_en_o", q_en_o, m_cfg[20]);
  endtask

  // inputs applied at negedge, checked 1 ns later, model advanced at posedge
  task automatic step(input string tag, input logic we, input logic par,
      input logic sb, input logic [CW-1:0] wd, input logic [2:0] xv,
      input logic wv, input logic mv, input logic dv, input logic cev,
      input logic sv, input logic cv);
    logic nq, fc;
    logic [CW-1:0] nc;
    cfg_we = we; cfg_par = par; cfg_bit = sb; cfg_word = wd;
    x = xv; w = wv; m = mv; d = dv; ce = cev; set_s = sv; clr = cv;
    #1;
    check_now(tag);
    fc = model_f();
    if (cv) nq = 1'b0;
    else if (sv) nq = 1'b1;
    else if (cev && !we) nq = m_cfg[19] ? dv : fc;
    else nq = m_q;
    if (we) nc = par ? wd : {m_cfg[CW-2:0], sb};
    else nc = m_cfg;
    @(posedge clk);
    m_q = nq; m_cfg = nc;
    @(negedge clk);
  endtask

  task automatic load(input string tag, input logic [CW-1:0] wd);
    step(tag, 1, 1, 0, wd, 3'd0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic comb(input string tag, input logic [2:0] xv, input logic wv, input logic mv);
    step(tag, 0, 0, 0, '0, xv, wv, mv, 0, 0, 0, 0);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] sw;
    cfg_we = 0; cfg_par = 0; cfg_bit = 0; cfg_word = '0;
    x = 0; w = 0; m = 0; d = 0; ce = 0; set_s = 0; clr = 0;
    m_cfg = '0; m_q = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    #1; check_now("R11");
    @(negedge clk);

    // R9 / R1: split mode, majority and parity
    load("R9", mk(8'hE8, 8'h96, 0, 0, 0, 0, 1, 1));
    for (int i = 0; i < 8; i++) comb("R1", 3'(i), 1'(i & 1), 0);

    // R2: joined mode over all 16 indexes
    load("R9", mk(8'h69, 8'hC3, 1, 0, 0, 0, 1, 1));
    for (int i = 0; i < 16; i++) comb("R2", 3'(i), 1'(i >> 3), 0);

    // R3: front AND
    load("R9", mk(8'hAA, 8'h0F, 0, 1, 0, 0, 1, 1));
    for (int i = 0; i < 16; i++) comb("R3", 3'(i), 0, 1'(i >> 3));

    // R5: capture, priorities, hold
    load("R9", mk(8'hFF, 8'h00, 0, 0, 0, 0, 1, 1));
    step("R5", 0, 0, 0, '0, 3'd0, 0, 0, 0, 1, 0, 0);
    step("R5", 0, 0, 0, '0, 3'd0, 0, 0, 0, 1, 1, 1);
    step("R5", 0, 0, 0, '0, 3'd0, 0, 0, 0, 1, 1, 0);
    step("R5", 0, 0, 0, '0, 3'd0, 0, 0, 0, 0, 0, 1);
    step("R5", 0, 0, 0, '0, 3'd0, 0, 0, 0, 0, 0, 0);
    step("R5", 0, 0, 0, '0, 3'd0, 0, 0, 0, 1, 0, 0);
    step("R5", 0, 0, 0, '0, 3'd0, 0, 0, 0, 0, 0, 0);

    // R6: write with ce high must not capture; set still acts
    step("R6", 1, 1, 0, mk(8'h00, 8'h00, 0, 0, 0, 0, 1, 1), 3'd0, 0, 0, 0, 1, 0, 0);
    step("R6", 0, 0, 0, '0, 3'd0, 0, 0, 0, 0, 0, 1);
    step("R6", 1, 1, 0, mk(8'hFF, 8'h00, 0, 0, 0, 0, 1, 1), 3'd0, 0, 0, 0, 1, 0, 0);
    step("R6", 1, 1, 0, mk(8'h00, 8'h00, 0, 0, 0, 0, 1, 1), 3'd0, 0, 0, 0, 1, 1, 0);
    step("R6", 0, 0, 0, '0, 3'd0, 0, 0, 0, 0, 0, 0);

    // R7: bypass data
    load("R9", mk(8'h00, 8'h00, 0, 0, 0, 1, 1, 1));
    for (int i = 0; i < 4; i++) step("R7", 0, 0, 0, '0, 3'd0, 0, 0, 1'(i), 1, 0, 0);

    // R4: toggle via feedback, table = !x2
    load("R9", mk(8'h0F, 8'hF0, 0, 0, 1, 0, 1, 1));
    step("R4", 0, 0, 0, '0, 3'd0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 6; i++) step("R4", 0, 0, 0, '0, 3'(i), 0, 0, 0, 1, 0, 0);

    // R8: outputs off, state kept, then on again
    load("R8", mk(8'h0F, 8'hF0, 0, 0, 1, 0, 0, 0));
    for (int i = 0; i < 3; i++) step("R8", 0, 0, 0, '0, 3'(i), 0, 0, 0, 1, 0, 0);
    load("R8", mk(8'h0F, 8'hF0, 0, 0, 1, 0, 1, 1));
    comb("R8", 3'd0, 0, 0);

    // R10: serial load, MSB first
    sw = mk(8'h5C, 8'h3A, 0, 0, 0, 0, 1, 1);
    for (int i = CW - 1; i >= 0; i--) step("R10", 1, 0, sw[i], '0, 3'd0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) comb("R10", 3'(i), 0, 0);

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[31:29] == 3'd0)
        step("R9", 1, 1, 0, CW'($urandom), 3'd0, 0, 0, 0, r[0], 0, 0);
      else
        step("R1", 0, 0, 0, '0, r[2:0], r[3], r[4], r[5], r[6], r[7] & r[8], r[9] & r[10] & r[11]);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule